// File: doc/BRIEF.md
# UART interrupt enable and identification

This block holds the interrupt enable byte and the two live interrupt sources of a classic PC-style serial port: received data available (RX) and transmit holding register empty (TX). Four single-cycle strobes come in, already decoded from the register bus: an enable write with its data byte, an identification read, a receive buffer read and a transmit holding write. A level input tells the block whether receive data is waiting. The block produces the identification byte that the bus returns, the stored enable byte and one interrupt request line.

The block keeps one pending bit for each source. Pending bits are raised through two one-shot delay timers, one per source. The TX source is the exception: when enabling TX after a long quiet period, it is raised on the next cycle instead. A saturating counter measures the cycles since the last TX raise and decides between these two paths. Line-status and modem-status enables are stored but never raise anything.

The enable byte is used as written. When an enable write and a timer expiry fall in the same cycle, the timer is gated by the enable value being written. A receive buffer read samples `rx_avail_i` in its own strobe cycle, taken as the state after that read.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `iir_o` is 0x01, `irq_o` is 0 and `ier_o` is 0x00. `ier_o` returns the full byte of the last enable write on the cycle after the write.
- R2: `iir_o` bit 0 is 0 when any source is pending and 1 otherwise. Bits 2:1 hold the source code: modem status 0, TX 1, RX 2, line status 3. Bits 7:3 are zero. An idle block therefore reads 0x01, TX reads 0x02 and RX reads 0x04. Enable bits 2 and 3, and bits 7:4, never raise an interrupt.
- R3: When RX and TX are both pending, `iir_o` reports RX (0x04).
- R4: An identification read while TX is the reported source clears TX pending on the next cycle. An identification read while RX is reported leaves both RX and TX pending.
- R5: A transmit holding write clears TX pending on the next cycle. If enable bit 1 is set, TX pending rises SCHED_DLY cycles after the write.
- R6: An enable write with bit 1 set raises TX pending on the next cycle if more than TX_GAP_CYC cycles have passed since the last TX raise (or since reset). Otherwise TX pending rises SCHED_DLY cycles after the write.
- R7: An enable write with bit 1 clear clears TX pending and cancels a scheduled TX raise. An enable write with bit 0 clear, or with `rx_avail_i` low, clears RX pending and cancels a scheduled RX raise. A scheduled raise takes effect only if its enable bit is still set when it expires.
- R8: A receive buffer read clears RX pending on the next cycle. If `rx_avail_i` is high and enable bit 0 is set, RX pending rises SCHED_DLY cycles after the read.
- R9: `irq_o` is high exactly when RX or TX is pending. It falls in the same cycle that the last pending bit clears.
- R10: An enable write with bit 0 set while `rx_avail_i` is high raises RX pending SCHED_DLY cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| iir_rd_i | input | 1 | Identification register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| rx_avail_i | input | 1 | Receive data waiting |
| iir_o | output | 8 | Identification byte |
| ier_o | output | 8 | Stored enable byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Each strobe is registered once. Clears, immediate TX raises and enable updates are therefore visible on the cycle after the strobe. Scheduled raises appear exactly SCHED_DLY cycles after the strobe that started them, and the quiet-window decision uses a count of edges since the last TX raise. The bench drives each strobe for one edge from the falling edge. It steps a cycle model of the requirements at that same rising edge and compares all three outputs one time unit later. Directed sequences pin each requirement to fixed byte values, using a small configuration (window 6 cycles, delay 3 cycles). A long random sweep of single strobes then exercises interleavings against the model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned EN_RX  = 0;
  localparam int unsigned EN_TX  = 1;
  localparam int unsigned SRC_RX = 0;
  localparam int unsigned SRC_TX = 1;
  localparam int unsigned NSRC   = 2;

  typedef enum logic [1:0] {
    ID_MODEM = 2'd0,
    ID_TX    = 2'd1,
    ID_RX    = 2'd2,
    ID_LINE  = 2'd3
  } irq_id_e;
endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int unsigned DLY = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic fire_o
);
  localparam int unsigned CW = (DLY < 1) ? 1 : $clog2(DLY + 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  assign fire_o = armed_q && (cnt_q == CW'(1));

  // cancel beats start, start re-arms a running timer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cancel_i) begin
      armed_q <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= CW'(DLY);
    end else if (fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q   <= cnt_q - CW'(1);
    end
  end

  // R7
  cancel_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !fire_o && !armed_q);
endmodule

// File: rtl/tx_gap_tracker.sv
module tx_gap_tracker #(
  parameter int unsigned GAP = 45
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  output logic expired_o
);
  localparam int unsigned GW  = $clog2(GAP + 2);
  localparam int unsigned SAT = GAP + 1;

  logic [GW-1:0] since_q;

  assign expired_o = since_q > GW'(GAP);

  // reset value is saturated: no TX raise has happened yet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_q <= GW'(SAT);
    else if (raise_i)             since_q <= '0;
    else if (since_q != GW'(SAT)) since_q <= since_q + GW'(1);
  end

  // R6
  raise_restarts_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> !expired_o);
endmodule

// File: rtl/irq_ident_enc.sv
module irq_ident_enc
  import uart_irq_pkg::*;
(
  input  logic       rx_pend_i,
  input  logic       tx_pend_i,
  output logic [7:0] iir_o
);
  irq_id_e id;

  always_comb begin
    if (rx_pend_i)      id = ID_RX;
    else if (tx_pend_i) id = ID_TX;
    else                id = ID_MODEM;
    iir_o = {5'b0, id, ~(rx_pend_i | tx_pend_i)};
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned TX_GAP_CYC = 45,
  parameter int unsigned SCHED_DLY  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ier_wr_i,
  input  logic [7:0] ier_wdata_i,
  input  logic       iir_rd_i,
  input  logic       rbr_rd_i,
  input  logic       thr_wr_i,
  input  logic       rx_avail_i,
  output logic [7:0] iir_o,
  output logic [7:0] ier_o,
  output logic       irq_o
);
  logic [7:0]      ier_q;
  logic            rx_pend_q, tx_pend_q;
  logic            gap_expired;
  logic [NSRC-1:0] tmr_start, tmr_cancel, tmr_fire;
  logic            en_rx_eff, en_tx_eff;
  logic            tx_cancel, rx_kill, tx_imm;
  logic            tx_raise, rx_raise, tx_clr, rx_clr;

  // enable seen by this cycle's decisions: a write in flight wins
  always_comb begin
    en_rx_eff = ier_wr_i ? ier_wdata_i[EN_RX] : ier_q[EN_RX];
    en_tx_eff = ier_wr_i ? ier_wdata_i[EN_TX] : ier_q[EN_TX];

    tx_cancel = ier_wr_i && !ier_wdata_i[EN_TX];
    rx_kill   = ier_wr_i && !(ier_wdata_i[EN_RX] && rx_avail_i);
    tx_imm    = ier_wr_i && ier_wdata_i[EN_TX] && gap_expired;

    tx_raise  = !tx_cancel && !thr_wr_i &&
                ((tmr_fire[SRC_TX] && en_tx_eff) || tx_imm);
    rx_raise  = !rx_kill && !rbr_rd_i && tmr_fire[SRC_RX] && en_rx_eff;

    tx_clr    = tx_cancel || thr_wr_i || (iir_rd_i && tx_pend_q && !rx_pend_q);
    rx_clr    = rx_kill || rbr_rd_i;

    tmr_start[SRC_TX]  = (thr_wr_i && en_tx_eff) ||
                         (ier_wr_i && ier_wdata_i[EN_TX] && !gap_expired);
    tmr_cancel[SRC_TX] = tx_cancel;
    tmr_start[SRC_RX]  = (ier_wr_i && ier_wdata_i[EN_RX] && rx_avail_i) ||
                         (rbr_rd_i && rx_avail_i && en_rx_eff);
    tmr_cancel[SRC_RX] = rx_kill;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_tmr
    irq_delay_timer #(.DLY(SCHED_DLY)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (tmr_start[s]),
      .cancel_i(tmr_cancel[s]),
      .fire_o  (tmr_fire[s])
    );
  end

  tx_gap_tracker #(.GAP(TX_GAP_CYC)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raise_i  (tx_raise),
    .expired_o(gap_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q     <= '0;
      rx_pend_q <= 1'b0;
      tx_pend_q <= 1'b0;
    end else begin
      if (ier_wr_i) ier_q <= ier_wdata_i;
      if (tx_raise)    tx_pend_q <= 1'b1;
      else if (tx_clr) tx_pend_q <= 1'b0;
      if (rx_raise)    rx_pend_q <= 1'b1;
      else if (rx_clr) rx_pend_q <= 1'b0;
    end
  end

  irq_ident_enc u_enc (
    .rx_pend_i(rx_pend_q),
    .tx_pend_i(tx_pend_q),
    .iir_o    (iir_o)
  );

  assign ier_o = ier_q;
  assign irq_o = rx_pend_q | tx_pend_q;

  // R9
  irq_matches_iir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != iir_o[0]);

  // R4
  iir_rd_clears_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && tx_pend_q && !rx_pend_q && !ier_wr_i && !tmr_fire[SRC_TX])
    |=> !tx_pend_q);

  // R4
  iir_rd_keeps_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && rx_pend_q && !rbr_rd_i && !ier_wr_i) |=> rx_pend_q);

  // R5
  thr_wr_clears_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !tx_pend_q);

  // R8
  rbr_rd_clears_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbr_rd_i |=> !rx_pend_q);

  // R7
  tx_disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_wr_i && !ier_wdata_i[EN_TX]) |=> !tx_pend_q);

  // R6
  tx_immediate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_wr_i && ier_wdata_i[EN_TX] && gap_expired && !thr_wr_i) |=> tx_pend_q);
endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
  localparam int GAP = 6;
  localparam int DLY = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_wr = 1'b0;
  logic [7:0] ier_wd = '0;
  logic       iir_rd = 1'b0;
  logic       rbr_rd = 1'b0;
  logic       thr_wr = 1'b0;
  logic       avail = 1'b0;
  logic [7:0] iir, ier;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model state
  logic [7:0] m_ier;
  logic       m_rx, m_tx, m_rxa, m_txa;
  int         m_rxc, m_txc, m_gap;

  always #2.5 clk = ~clk;

  uart_irq_ident #(.TX_GAP_CYC(GAP), .SCHED_DLY(DLY)) u_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .ier_wr_i(ier_wr), .ier_wdata_i(ier_wd),
    .iir_rd_i(iir_rd), .rbr_rd_i(rbr_rd), .thr_wr_i(thr_wr),
    .rx_avail_i(avail), .iir_o(iir), .ier_o(ier), .irq_o(irq)
  );

  function automatic logic [7:0] exp_iir();
    if (m_rx)      return 8'h04;
    else if (m_tx) return 8'h02;
    else           return 8'h01;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ier = '0; m_rx = 0; m_tx = 0; m_rxa = 0; m_txa = 0;
    m_rxc = 0; m_txc = 0; m_gap = GAP + 1;
  endtask

  task automatic model_step(input logic iw, input logic [7:0] wd,
                            input logic ir, input logic rr, input logic tw);
    logic fire_tx, fire_rx, en_tx, en_rx, gexp, can_tx, kill_rx;
    logic set_tx, set_rx, st_tx, st_rx, raised;
    fire_tx = m_txa && m_txc == 1;
    fire_rx = m_rxa && m_rxc == 1;
    en_tx   = iw ? wd[1] : m_ier[1];
    en_rx   = iw ? wd[0] : m_ier[0];
    gexp    = m_gap > GAP;
    can_tx  = iw && !wd[1];
    kill_rx = iw && !(wd[0] && avail);
    set_tx  = (fire_tx && en_tx) || (iw && wd[1] && gexp);
    set_rx  = fire_rx && en_rx;
    st_tx   = (tw && en_tx) || (iw && wd[1] && !gexp);
    st_rx   = (iw && wd[0] && avail) || (rr && avail && en_rx);
    raised  = 0;
    if (can_tx)                  m_tx = 0;
    else if (tw)                 m_tx = 0;
    else if (set_tx) begin       m_tx = 1; raised = 1; end
    else if (ir && m_tx && !m_rx) m_tx = 0;
    if (kill_rx)     m_rx = 0;
    else if (rr)     m_rx = 0;
    else if (set_rx) m_rx = 1;
    if (can_tx)              m_txa = 0;
    else if (st_tx) begin    m_txa = 1; m_txc = DLY; end
    else if (fire_tx)        m_txa = 0;
    else if (m_txa)          m_txc--;
    if (kill_rx)             m_rxa = 0;
    else if (st_rx) begin    m_rxa = 1; m_rxc = DLY; end
    else if (fire_rx)        m_rxa = 0;
    else if (m_rxa)          m_rxc--;
    if (raised)              m_gap = 0;
    else if (m_gap <= GAP)   m_gap++;
    if (iw) m_ier = wd;
  endtask

  task automatic step(input logic iw, input logic [7:0] wd,
                      input logic ir, input logic rr, input logic tw);
    @(negedge clk);
    ier_wr = iw; ier_wd = wd; iir_rd = ir; rbr_rd = rr; thr_wr = tw;
    @(posedge clk);
    model_step(iw, wd, ir, rr, tw);
    #1;
    chk("R2 iir vs model", iir, exp_iir());
    chk("R1 ier vs model", ier, m_ier);
    chk("R9 irq vs model", {7'b0, irq}, {7'b0, m_rx | m_tx});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 reset iir", iir, 8'h01);
    chk("R1 reset ier", ier, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);

    // R2 line/modem enables and upper bits never interrupt
    step(1, 8'hFC, 0, 0, 0); idle(4);
    chk("R1 ier readback", ier, 8'hFC);
    chk("R2 no interrupt from bits 2,3,7:4", iir, 8'h01);

    // R6 immediate TX after quiet period
    step(1, 8'h02, 0, 0, 0);
    chk("R6 immediate tx", iir, 8'h02);
    chk("R9 irq high", {7'b0, irq}, 8'h01);

    // R4 identification read clears TX
    step(0, 8'h00, 1, 0, 0);
    chk("R4 iir read clears tx", iir, 8'h01);
    chk("R9 irq falls same cycle", {7'b0, irq}, 8'h00);

    // R6 re-enable inside the window: delayed
    step(1, 8'h00, 0, 0, 0);
    step(1, 8'h02, 0, 0, 0);
    chk("R6 not immediate inside window", iir, 8'h01);
    idle(2);
    chk("R6 not yet at DLY-1", iir, 8'h01);
    idle(1);
    chk("R6 delayed tx at DLY", iir, 8'h02);

    // R5 transmit write clears, then re-raises after DLY
    step(0, 8'h00, 0, 0, 1);
    chk("R5 thr write clears tx", iir, 8'h01);
    idle(2);
    chk("R5 not yet", iir, 8'h01);
    idle(1);
    chk("R5 tx after DLY", iir, 8'h02);

    // R10 + R3: RX scheduled by enable write with data; RX outranks TX
    avail = 1'b1;
    step(1, 8'h03, 0, 0, 0);
    idle(3);
    chk("R10 rx raised after DLY", iir, 8'h04);
    chk("R3 rx over tx", iir, 8'h04);

    // R4 identification read while RX reported keeps both
    step(0, 8'h00, 1, 0, 0);
    chk("R4 rx kept on iir read", iir, 8'h04);

    // R8 receive read clears RX, re-raises with data still there
    step(0, 8'h00, 0, 1, 0);
    chk("R8 rbr read clears rx", iir, 8'h02);
    idle(3);
    chk("R8 rx re-raised", iir, 8'h04);
    avail = 1'b0;
    step(0, 8'h00, 0, 1, 0);
    idle(4);
    chk("R8 no re-raise without data", iir, 8'h02);
    step(0, 8'h00, 1, 0, 0);
    chk("R9 irq low when none", {7'b0, irq}, 8'h00);

    // R7 cancellation of scheduled raises
    step(0, 8'h00, 0, 0, 1);
    step(1, 8'h01, 0, 0, 0);
    idle(4);
    chk("R7 tx cancel", iir, 8'h01);
    avail = 1'b1;
    step(1, 8'h01, 0, 0, 0);
    step(1, 8'h00, 0, 0, 0);
    idle(4);
    chk("R7 rx cancel", iir, 8'h01);
    avail = 1'b0;
    step(1, 8'h01, 0, 0, 0);
    idle(4);
    chk("R7 rx enable without data", iir, 8'h01);

    // random sweep against the model
    for (int k = 0; k < 4000; k++) begin
      int op;
      op = $urandom_range(0, 11);
      case (op)
        3:       step(1, 8'($urandom_range(0, 255)), 0, 0, 0);
        4:       step(0, 8'h00, 1, 0, 0);
        5:       step(0, 8'h00, 0, 1, 0);
        6:       step(0, 8'h00, 0, 0, 1);
        7: begin avail = ~avail; step(0, 8'h00, 0, 0, 0); end
        8:       idle(GAP + 2);
        default: step(0, 8'h00, 0, 0, 0);
      endcase
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule